// File: doc/BRIEF.md
# Block-Transfer I2C Configuration Slave

This block is an I2C slave that holds eight 8-bit configuration bytes for a clock device. It has no register pointer, so every transfer has a fixed shape. A write starts with two header bytes that are acknowledged and thrown away. The bytes that follow fill the registers from index 0 upward until the host sends a stop. A read always begins with a count byte, followed by the registers in ascending order.

The bus lines are sampled by the system clock. Each passes through a two-flop synchronizer and a glitch filter. The slave pulls SDA low through an open-drain enable. The register contents are always visible on a flat parallel output, so the clock logic next to the block can use them directly.

The controller has seven named states:
- **IDLE**: waits for a start.
- **ADDR**: shifts in the address byte.
- **ADDR_ACK**: acknowledges a matching address.
- **WR_BYTE** and **WR_ACK**: receive a write byte, then acknowledge it.
- **RD_BYTE** and **RD_ACK**: transmit a byte, then sample the host's acknowledge.

The transitions are:
- IDLE→ADDR on a start.
- ADDR→ADDR_ACK on an address match; ADDR→IDLE on a mismatch.
- ADDR_ACK→WR_BYTE or →RD_BYTE, chosen by the R/W bit.
- WR_BYTE→WR_ACK, and WR_ACK→WR_BYTE.
- RD_BYTE→RD_ACK, and RD_ACK→RD_BYTE when the host acknowledges.
- RD_ACK→IDLE when the host does not acknowledge.
- From any state: →IDLE on a stop, and →ADDR on a start (repeated start).

Top module: `clkcfg_i2c_slave`

## Requirements
- R1: After reset, `cfg_regs` equals the `REG_DEFAULTS` parameter and `sda_oe` is 0. Byte k is at bits [8k+7:8k], and `sda_oe`=1 means SDA is pulled low.
- R2: The slave acknowledges the address byte D4h (write) and D5h (read). Any other address is not acknowledged, and the slave ignores the bus until the next start.
- R3: In a write, the two bytes after the address are acknowledged and do not change any register.
- R4: In a write, the third and later bytes are stored into registers 0, 1, 2, … in order, and each one is acknowledged.
- R5: A stop after any complete byte ends the write. Registers not reached keep their values.
- R6: Write bytes past register 7 are acknowledged and discarded.
- R7: A read sends the count byte 08h first, then registers 0 to 7 MSB first, then FFh for any further bytes.
- R8: When the host does not acknowledge a read byte, the slave releases SDA and drives nothing until the next start.
- R9: `sda_oe` changes only while the filtered SCL is low.
- R10: A repeated start restarts the byte sequence. A following write begins again with the two header bytes, and a following read begins again with the count.
- R11: SCL pulses shorter than `FILT_LEN` clock cycles are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_regs | output | 8*NUM_REGS | All configuration bytes; byte k at [8k+7:8k] |

## Verification
The hardest situation to reach is a repeated start in the middle of a transfer. This happens after the byte index has already advanced, so it must be shown that the sequence restarts rather than continuing. The stimulus issues a start directly after an acknowledged data byte, then repeats the header, and checks that the next data byte lands in register 0 and that register 1 is unchanged. It then does the same from a write header into a read, which must begin with the count byte. A second hard case is the interval after a host NACK. There the stimulus keeps clocking a full byte with SDA released and expects all ones, which shows that the slave stays silent.

// File: rtl/clkcfg_pkg.sv
package clkcfg_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } slv_state_t;
endpackage

// File: rtl/clkcfg_sync_filter.sv
module clkcfg_sync_filter #(
    parameter int LINES    = 2,
    parameter int FILT_LEN = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] clean
);
    generate
        for (genvar g = 0; g < LINES; g++) begin : g_line
            logic [1:0]          sync_q;
            logic [FILT_LEN-1:0] hist_q;
            logic                line_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    sync_q <= 2'b11;
                    hist_q <= '1;
                    line_q <= 1'b1;
                end else begin
                    sync_q <= {sync_q[0], raw[g]};
                    hist_q <= {hist_q[FILT_LEN-2:0], sync_q[1]};
                    if (&hist_q)
                        line_q <= 1'b1;
                    else if (~|hist_q)
                        line_q <= 1'b0;
                end
            end

            assign clean[g] = line_q;
        end
    endgenerate
endmodule

// File: rtl/clkcfg_bus_events.sv
module clkcfg_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl,
    input  logic sda,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl;
            sda_q <= sda;
        end
    end

    assign scl_rise = scl & ~scl_q;
    assign scl_fall = ~scl & scl_q;
    assign start_ev = scl & scl_q & sda_q & ~sda;
    assign stop_ev  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/clkcfg_regfile.sv
module clkcfg_regfile #(
    parameter int                    NUM_REGS     = 8,
    parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = '0,
    localparam int                   AW           = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [AW-1:0]         waddr,
    input  logic [7:0]            wdata,
    output logic [NUM_REGS*8-1:0] regs_flat
);
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            logic [7:0] byte_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    byte_q <= REG_DEFAULTS[8*g +: 8];
                else if (we && waddr == AW'(g))
                    byte_q <= wdata;
            end

            assign regs_flat[8*g +: 8] = byte_q;
        end
    endgenerate
endmodule

// File: rtl/clkcfg_i2c_slave.sv
module clkcfg_i2c_slave
    import clkcfg_pkg::*;
#(
    parameter logic [6:0]            DEV_ADDR     = 7'h6A,
    parameter int                    NUM_REGS     = 8,
    parameter int                    FILT_LEN     = 3,
    parameter logic [NUM_REGS*8-1:0] REG_DEFAULTS = 64'h5A_E5_FF_00_3C_0F_81_C3
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  scl_i,
    input  logic                  sda_i,
    output logic                  sda_oe,
    output logic [NUM_REGS*8-1:0] cfg_regs
);
    localparam int               HDR_BYTES = 2;
    localparam int               AW        = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
    localparam int               IDX_W     = $clog2(NUM_REGS + HDR_BYTES + 1) + 1;
    localparam logic [IDX_W-1:0] IDX_MAX   = '1;

    logic [1:0] line_clean;
    logic       scl_f, sda_f;
    logic       scl_rise, scl_fall, start_ev, stop_ev;

    slv_state_t       state, nstate;
    logic [3:0]       bitcnt;
    logic [7:0]       rx_sh, tx_sh, tx_byte;
    logic [IDX_W-1:0] idx, idx_inc;
    logic             host_nack;
    logic             byte_done, addr_hit;
    logic             wr_en;
    logic [AW-1:0]    wr_addr;

    clkcfg_sync_filter #(.LINES(2), .FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   ({scl_i, sda_i}),
        .clean (line_clean)
    );
    assign scl_f = line_clean[1];
    assign sda_f = line_clean[0];

    clkcfg_bus_events u_evt (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl      (scl_f),
        .sda      (sda_f),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_ev (start_ev),
        .stop_ev  (stop_ev)
    );

    clkcfg_regfile #(.NUM_REGS(NUM_REGS), .REG_DEFAULTS(REG_DEFAULTS)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .we        (wr_en),
        .waddr     (wr_addr),
        .wdata     (rx_sh),
        .regs_flat (cfg_regs)
    );

    assign byte_done = (bitcnt == 4'd8) && scl_fall;
    assign addr_hit  = (rx_sh[7:1] == DEV_ADDR);
    assign idx_inc   = (idx == IDX_MAX) ? idx : idx + IDX_W'(1);

    // Byte handed to the shifter: count, then registers, then all ones
    always_comb begin
        tx_byte = 8'hFF;
        if (idx == '0)
            tx_byte = 8'(NUM_REGS);
        for (int k = 0; k < NUM_REGS; k++)
            if (idx == IDX_W'(k + 1))
                tx_byte = cfg_regs[8*k +: 8];
    end

    // Next-state logic
    always_comb begin
        nstate = state;
        if (stop_ev)
            nstate = ST_IDLE;
        else if (start_ev)
            nstate = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE:     nstate = ST_IDLE;
                ST_ADDR:     if (byte_done) nstate = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall) nstate = rx_sh[0] ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (byte_done) nstate = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall) nstate = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bitcnt == 4'd7) nstate = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall) nstate = host_nack ? ST_IDLE : ST_RD_BYTE;
                default:     nstate = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= nstate;
    end

    // Shifters, bit counter and byte index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bitcnt    <= '0;
            rx_sh     <= '0;
            tx_sh     <= 8'hFF;
            idx       <= '0;
            host_nack <= 1'b0;
        end else if (start_ev) begin
            bitcnt    <= '0;
            idx       <= '0;
            host_nack <= 1'b0;
        end else begin
            unique case (state)
                ST_ADDR, ST_WR_BYTE: begin
                    if (scl_rise) begin
                        rx_sh  <= {rx_sh[6:0], sda_f};
                        bitcnt <= bitcnt + 4'd1;
                    end
                    if (state == ST_WR_BYTE && byte_done)
                        idx <= idx_inc;
                end
                ST_ADDR_ACK: if (scl_fall) begin
                    bitcnt <= '0;
                    if (rx_sh[0]) begin
                        tx_sh <= tx_byte;
                        idx   <= idx_inc;
                    end
                end
                ST_WR_ACK: if (scl_fall) bitcnt <= '0;
                ST_RD_BYTE: if (scl_fall && bitcnt != 4'd7) begin
                    tx_sh  <= {tx_sh[6:0], 1'b1};
                    bitcnt <= bitcnt + 4'd1;
                end
                ST_RD_ACK: begin
                    if (scl_rise)
                        host_nack <= sda_f;
                    if (scl_fall && !host_nack) begin
                        tx_sh  <= tx_byte;
                        idx    <= idx_inc;
                        bitcnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        sda_oe  = 1'b0;
        wr_en   = 1'b0;
        wr_addr = AW'(idx - IDX_W'(HDR_BYTES));
        unique case (state)
            ST_ADDR_ACK, ST_WR_ACK: sda_oe = 1'b1;
            ST_RD_BYTE:             sda_oe = ~tx_sh[7];
            ST_WR_BYTE: wr_en = byte_done && !start_ev && !stop_ev &&
                                idx >= IDX_W'(HDR_BYTES) &&
                                idx <  IDX_W'(HDR_BYTES + NUM_REGS);
            default: ;
        endcase
    end
endmodule

// File: rtl/clkcfg_i2c_checker.sv
module clkcfg_i2c_checker
    import clkcfg_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  scl_f,
    input logic                  start_ev,
    input logic                  stop_ev,
    input logic                  sda_oe,
    input logic [NUM_REGS*8-1:0] cfg_regs,
    input slv_state_t            state
);
    assert_oe_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f);

    assert_stop_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_ev |=> !sda_oe);

    assert_restart_seq_R10: assert property (@(posedge clk) disable iff (!rst_n)
        start_ev |=> (state == ST_ADDR));

    assert_event_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_ev, stop_ev}));

    assert_reg_write_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_regs != $past(cfg_regs)) |-> ($past(state) == ST_WR_BYTE));

    assert_addr_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR) |-> !sda_oe);
endmodule

bind clkcfg_i2c_slave clkcfg_i2c_checker #(.NUM_REGS(NUM_REGS)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .sda_oe   (sda_oe),
    .cfg_regs (cfg_regs),
    .state    (state)
);

// File: tb/clkcfg_i2c_slave_bench.sv
module clkcfg_i2c_slave_bench;
    localparam logic [63:0] DEF = 64'h12_34_56_78_9A_BC_DE_F0;
    localparam int          Q   = 20;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_scl = 1'b1;
    logic        host_sda = 1'b1;
    logic        sda_line;
    logic        sda_oe;
    logic [63:0] cfg_regs;

    always #5 clk = ~clk;
    assign sda_line = host_sda & ~sda_oe;

    clkcfg_i2c_slave #(.REG_DEFAULTS(DEF)) u_clkcfg_i2c_slave (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (host_scl),
        .sda_i    (sda_line),
        .sda_oe   (sda_oe),
        .cfg_regs (cfg_regs)
    );

    typedef struct {
        string req;
        int    val;
    } item_t;

    int         checks = 0;
    int         fails = 0;
    int         oe_bad = 0;
    logic       prev_oe = 1'b0;
    item_t      exp_q[$];
    item_t      obs_q[$];
    logic [7:0] model[8];

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic q_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_regs(input string req);
        for (int k = 0; k < 8; k++)
            check(req, int'(cfg_regs[8*k +: 8]), int'(model[k]));
    endtask

    task automatic bus_start();
        host_sda = 1'b1; q_wait(Q);
        host_scl = 1'b1; q_wait(Q);
        host_sda = 1'b0; q_wait(Q);
        host_scl = 1'b0; q_wait(Q);
    endtask

    task automatic bus_stop();
        host_sda = 1'b0; q_wait(Q);
        host_scl = 1'b1; q_wait(Q);
        host_sda = 1'b1; q_wait(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input int exp_ack,
                             input string req, input bit glitch);
        exp_q.push_back('{req, exp_ack});
        for (int i = 7; i >= 0; i--) begin
            host_sda = b[i];
            q_wait(Q);
            if (glitch && i == 4) begin
                host_scl = 1'b1; q_wait(1);
                host_scl = 1'b0; q_wait(Q);
            end
            host_scl = 1'b1; q_wait(2*Q);
            host_scl = 1'b0; q_wait(Q);
        end
        host_sda = 1'b1; q_wait(Q);
        host_scl = 1'b1; q_wait(Q);
        obs_q.push_back('{req, (sda_line == 1'b0) ? 1 : 0});
        q_wait(Q);
        host_scl = 1'b0; q_wait(Q);
    endtask

    task automatic read_byte(input logic [7:0] exp, input bit host_ack, input string req);
        logic [7:0] got;
        exp_q.push_back('{req, int'(exp)});
        host_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            q_wait(Q);
            host_scl = 1'b1; q_wait(Q);
            got[i] = sda_line;
            q_wait(Q);
            host_scl = 1'b0;
        end
        obs_q.push_back('{req, int'(got)});
        q_wait(Q);
        host_sda = host_ack ? 1'b0 : 1'b1; q_wait(Q);
        host_scl = 1'b1; q_wait(2*Q);
        host_scl = 1'b0; q_wait(Q);
        host_sda = 1'b1;
    endtask

    // Scoreboard monitor
    initial begin
        forever begin
            item_t o, e;
            wait (obs_q.size() > 0);
            o = obs_q.pop_front();
            if (exp_q.size() == 0) begin
                checks++; fails++;
                $display("FAIL %s actual=%0h expected=none", o.req, o.val);
            end else begin
                e = exp_q.pop_front();
                check(e.req, o.val, e.val);
            end
        end
    end

    // R9: open-drain enable must not move while the host holds SCL high
    always @(negedge clk) begin
        if (rst_n && sda_oe !== prev_oe && host_scl)
            oe_bad++;
        prev_oe <= sda_oe;
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        for (int k = 0; k < 8; k++) model[k] = DEF[8*k +: 8];
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        q_wait(2);
        check_regs("R1");
        check("R1", int'(sda_oe), 0);

        // Full write: header bytes, eight data bytes, two surplus bytes
        bus_start();
        send_byte(8'hD4, 1, "R2", 1'b0);
        send_byte(8'h55, 1, "R3", 1'b0);
        send_byte(8'h99, 1, "R3", 1'b0);
        for (int k = 0; k < 8; k++) begin
            send_byte(8'hA0 + 8'(k), 1, "R4", 1'b0);
            model[k] = 8'hA0 + 8'(k);
        end
        send_byte(8'h11, 1, "R6", 1'b0);
        send_byte(8'h22, 1, "R6", 1'b0);
        bus_stop();
        check_regs("R4");
        check("R3", int'(cfg_regs[7:0]), 'hA0);
        check("R6", int'(cfg_regs[63:56]), 'hA7);

        // Partial write with an SCL glitch inside the first data byte
        bus_start();
        send_byte(8'hD4, 1, "R2", 1'b0);
        send_byte(8'h00, 1, "R3", 1'b0);
        send_byte(8'h00, 1, "R3", 1'b0);
        send_byte(8'h01, 1, "R11", 1'b1);
        send_byte(8'h02, 1, "R5", 1'b0);
        send_byte(8'h03, 1, "R5", 1'b0);
        bus_stop();
        model[0] = 8'h01; model[1] = 8'h02; model[2] = 8'h03;
        check_regs("R5");
        check("R11", int'(cfg_regs[7:0]), 'h01);

        // Read: count, registers, one overrun byte with NACK, then silence
        bus_start();
        send_byte(8'hD5, 1, "R2", 1'b0);
        read_byte(8'h08, 1'b1, "R7");
        for (int k = 0; k < 8; k++)
            read_byte(model[k], 1'b1, "R7");
        read_byte(8'hFF, 1'b0, "R7");
        read_byte(8'hFF, 1'b0, "R8");
        bus_stop();

        // Foreign address: no acknowledge, bus ignored
        bus_start();
        send_byte(8'hA4, 0, "R2", 1'b0);
        send_byte(8'h00, 0, "R2", 1'b0);
        bus_stop();
        check_regs("R2");

        // Repeated start inside a write restarts the header sequence
        bus_start();
        send_byte(8'hD4, 1, "R10", 1'b0);
        send_byte(8'h00, 1, "R10", 1'b0);
        send_byte(8'h00, 1, "R10", 1'b0);
        send_byte(8'h77, 1, "R10", 1'b0);
        bus_start();
        send_byte(8'hD4, 1, "R10", 1'b0);
        send_byte(8'h00, 1, "R10", 1'b0);
        send_byte(8'h00, 1, "R10", 1'b0);
        send_byte(8'h88, 1, "R10", 1'b0);
        bus_stop();
        model[0] = 8'h88;
        check("R10", int'(cfg_regs[7:0]), 'h88);
        check("R10", int'(cfg_regs[15:8]), 'h02);

        // Write header followed by repeated start into a read
        bus_start();
        send_byte(8'hD4, 1, "R10", 1'b0);
        send_byte(8'h00, 1, "R10", 1'b0);
        bus_start();
        send_byte(8'hD5, 1, "R10", 1'b0);
        read_byte(8'h08, 1'b1, "R10");
        read_byte(model[0], 1'b0, "R10");
        bus_stop();

        wait (obs_q.size() == 0);
        q_wait(5);
        check("R9", oe_bad, 0);
        check("R7", exp_q.size(), 0);
        finish_run();
    end
endmodule